// File: doc/BRIEF.md
# Keyboard Scan Code Holding Buffer

This block sits between a serial keyboard receiver and a host processor. Each scan code that the receiver delivers lands in one holding register. The block then raises an interrupt request so that the host knows a code is waiting. The host sees two byte-wide locations, chosen by one address bit. Location 0 is the data location. A read there returns the held code, and a write there queues one byte for transmission to the keyboard. Location 1 is the status/command location. A read there returns the flag byte, and a write there issues a controller command.

There is one holding entry and no queue. If a code arrives while the previous one is still unread, the new code is lost and a sticky overrun flag is raised. The outgoing path also holds one byte. It is offered to the keyboard side with a valid/ready pair, and a status flag reports it as busy until the keyboard side accepts it. Two controller command values switch keyboard reception off and back on. Every command byte written to location 1 is also passed out on a one-cycle strobe.

Top module: `kbd_data_buffer`

## Requirements
- R1: After reset the status byte reads 0x00, `irq` is low, `tx_valid` is low and reception is switched on.
- R2: A code presented with `rx_valid` while the holding register is empty is stored. From the following cycle `irq` is high and status bit 0 reads 1, and a read of address 0 returns that code.
- R3: A read of address 0 clears status bit 0 and `irq` from the next cycle. A code that arrives in the same cycle as such a read is stored, and bit 0 stays set.
- R4: A code that arrives while the holding register is full and no data read takes place is dropped. The held code is kept and status bit 2 (overrun) is set. Bit 2 stays set until the next read of address 0 clears it.
- R5: A write to address 0 while not busy puts the byte on `tx_data`, with `tx_valid` and status bit 1 high from the next cycle. Both stay high, with `tx_data` unchanged, until the cycle after `tx_ready` is seen high.
- R6: A write to address 0 while busy is ignored. `tx_data` keeps the earlier byte.
- R7: A write to address 1 drives `ctl_cmd_stb` high in that same cycle, with the written byte on `ctl_cmd`.
- R8: The command byte CMD_OFF (default 0xAD) switches reception off, and status bit 3 then reads 1. CMD_ON (default 0xAE) switches it back on. While reception is off, arriving codes are neither stored nor counted as overrun.
- R9: Status bits 7..4 read 0. A status read changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | Register select: 0 = data, 1 = status/command |
| rd_stb | input | 1 | Single-cycle host read strobe |
| wr_stb | input | 1 | Single-cycle host write strobe |
| wr_data | input | DW | Host write byte |
| rd_data | output | DW | Host read byte for the selected location |
| irq | output | 1 | Code waiting interrupt request |
| rx_valid | input | 1 | Receiver delivers a scan code this cycle |
| rx_code | input | DW | Scan code from the receiver |
| tx_valid | output | 1 | Outgoing byte pending for the keyboard |
| tx_data | output | DW | Outgoing byte |
| tx_ready | input | 1 | Keyboard side accepts the outgoing byte |
| ctl_cmd_stb | output | 1 | Controller command strobe |
| ctl_cmd | output | DW | Controller command byte |

## Verification
The receive path is exercised with four arrival patterns. An isolated arrival and a read check plain storage and the clearing of the interrupt. Two arrivals with no read between them separate drop-newest behaviour from overwrite. An arrival in the same cycle as a data read shows whether the clear wins over the refill. Arrivals while reception is switched off show that the on/off commands act on the receive path. The transmit path is tried with a stalled ready, a second write while stalled, and a write overlapping a pending receive code, which shows that the two status bits are independent.

// File: rtl/kbd_data_buffer.sv
module kbd_data_buffer #(
  parameter int DW = 8,
  parameter logic [DW-1:0] CMD_OFF = 8'hAD,
  parameter logic [DW-1:0] CMD_ON  = 8'hAE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          irq,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_code,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready,
  output logic          ctl_cmd_stb,
  output logic [DW-1:0] ctl_cmd
);

  localparam int FLAGS = 4;

  logic [DW-1:0] held, tx_q;
  logic full, ovr, busy, off;

  wire data_rd = rd_stb & ~addr;
  wire data_wr = wr_stb & ~addr;
  wire cmd_wr  = wr_stb &  addr;
  wire take    = rx_valid & ~off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= '0;
      full <= 1'b0;
      ovr  <= 1'b0;
    end else if (data_rd) begin
      full <= take;
      ovr  <= 1'b0;
      if (take) held <= rx_code;
    end else if (take) begin
      if (!full) begin
        held <= rx_code;
        full <= 1'b1;
      end else begin
        ovr <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tx_q <= '0;
    end else if (busy && tx_ready) begin
      busy <= 1'b0;
    end else if (data_wr && !busy) begin
      busy <= 1'b1;
      tx_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           off <= 1'b0;
    else if (cmd_wr && wr_data == CMD_OFF) off <= 1'b1;
    else if (cmd_wr && wr_data == CMD_ON)  off <= 1'b0;
  end

  wire [DW-1:0] status = {{(DW-FLAGS){1'b0}}, off, ovr, busy, full};

  assign rd_data     = addr ? status : held;
  assign irq         = full;
  assign tx_valid    = busy;
  assign tx_data     = tx_q;
  assign ctl_cmd_stb = cmd_wr;
  assign ctl_cmd     = wr_data;

  a_r3_read_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !rx_valid) |=> !irq);

  a_r4_held_kept_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && rx_valid && !off && !data_rd) |=> ($stable(held) && ovr));

  a_r4_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !data_rd) |=> ovr);

  a_r5_tx_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  a_r8_off_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (off && !irq) |=> !irq);

endmodule

// File: tb/kbd_data_buffer_test.sv
module kbd_data_buffer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0, rx_valid = 1'b0, tx_ready = 1'b0;
  logic [7:0] wr_data = '0, rx_code = '0;
  logic [7:0] rd_data, tx_data, ctl_cmd;
  logic irq, tx_valid, ctl_cmd_stb;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  kbd_data_buffer uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .rx_valid(rx_valid),
    .rx_code(rx_code), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .ctl_cmd_stb(ctl_cmd_stb), .ctl_cmd(ctl_cmd)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_stb && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, rd_data, e);
    end
  end

  task automatic idle();
    @(posedge clk); #1;
    rd_stb = 0; wr_stb = 0; rx_valid = 0; tx_ready = 0;
  endtask

  task automatic push_code(logic [7:0] c);
    idle(); rx_valid = 1; rx_code = c;
  endtask

  task automatic host_read(logic a, logic [7:0] exp, string tag);
    idle(); addr = a; rd_stb = 1;
    exp_q.push_back(exp); tag_q.push_back(tag);
  endtask

  task automatic read_with_code(logic [7:0] exp, logic [7:0] c);
    idle(); addr = 0; rd_stb = 1; rx_valid = 1; rx_code = c;
    exp_q.push_back(exp); tag_q.push_back("R3 read+arrival data");
  endtask

  task automatic host_write(logic a, logic [7:0] d);
    idle(); addr = a; wr_stb = 1; wr_data = d;
  endtask

  initial begin
    #160000;
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle();
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
    host_read(1, 8'h00, "R1 status");

    push_code(8'h1C); idle();
    check("R2 irq", {7'b0, irq}, 8'h01);
    host_read(1, 8'h01, "R2 status");
    host_read(0, 8'h1C, "R2 data");
    idle();
    check("R3 irq cleared", {7'b0, irq}, 8'h00);
    host_read(1, 8'h00, "R3 status");

    push_code(8'h2A); push_code(8'h3B); idle();
    host_read(1, 8'h05, "R4 status overrun");
    host_read(1, 8'h05, "R9 status read no effect");
    host_read(0, 8'h2A, "R4 older kept");
    host_read(1, 8'h00, "R4 overrun cleared");
    idle();
    check("R4 irq", {7'b0, irq}, 8'h00);

    push_code(8'h44);
    read_with_code(8'h44, 8'h55);
    idle();
    check("R3 irq stays", {7'b0, irq}, 8'h01);
    host_read(1, 8'h01, "R3 status after refill");
    host_read(0, 8'h55, "R3 refilled code");

    host_write(0, 8'hED); idle();
    check("R5 tx_valid", {7'b0, tx_valid}, 8'h01);
    check("R5 tx_data", tx_data, 8'hED);
    host_read(1, 8'h02, "R5 status busy");
    host_write(0, 8'h11); idle(); idle();
    check("R6 tx_data kept", tx_data, 8'hED);
    push_code(8'h66); idle();
    host_read(1, 8'h03, "R5 busy with full");
    idle(); tx_ready = 1;
    idle();
    check("R5 tx_valid cleared", {7'b0, tx_valid}, 8'h00);
    host_read(1, 8'h01, "R5 status after accept");
    host_read(0, 8'h66, "R2 data during tx");

    host_write(1, 8'h60); #2;
    check("R7 strobe", {7'b0, ctl_cmd_stb}, 8'h01);
    check("R7 cmd", ctl_cmd, 8'h60);
    idle(); #2;
    check("R7 strobe low", {7'b0, ctl_cmd_stb}, 8'h00);

    host_write(1, 8'hAD); idle();
    host_read(1, 8'h08, "R8 off flag");
    push_code(8'h77); idle();
    check("R8 irq off", {7'b0, irq}, 8'h00);
    host_read(1, 8'h08, "R8 no store");
    host_write(1, 8'hAE); idle();
    host_read(1, 8'h00, "R8 back on");
    push_code(8'h78); idle();
    host_read(0, 8'h78, "R8 code after on");
    idle(); idle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule